// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a memory-mapped watchdog that a processor must service at regular intervals. A counter advances on ticks of an externally selected time base. An optional divide-by-256 stage can slow it further. When the count reaches the programmed limit, the block pulses a reset request and latches a timeout flag. Software cannot change the configuration or the limit by accident. It must first write a magic unlock key to the counter register. It services the timer with a different magic key written to the same register.

The bus is a plain single-cycle register port. A write is taken on any clock edge where `bus_wr` is high, and read data follows `bus_addr` combinationally. The port carries no data stream, so there is no valid/ready handshake and no back-pressure. The key format is chosen by the 32-bit-command bit of the control register. When the bit is set, a key is one whole word. When it is clear, a key is two halfword writes that must follow each other directly. The unlock window is short and closes by itself. Software can also freeze the configuration until the next reset.

Top module: `keyed_wdog`

## Requirements
- R1: The control/status register is at byte offset 0x0, the counter at 0x4 and the limit at 0x8. After reset, control/status reads 0x00000020 (only the allow-updates bit 5 is set), the counter reads 0, and the limit reads the TOVAL_RST parameter.
- R2: While control bit 13 (32-bit command mode) is 1, writing 0xD928C520 to the counter register unlocks. A halfword key written in this mode is not a key.
- R3: While bit 13 is 0, unlocking needs 0x0000C520 and then 0x0000D928 as two counter-register writes with no other bus write between them. A second half that arrives alone, or after an intervening write, is discarded.
- R4: Writes to the control/status and limit registers have no effect unless the unlocked bit (bit 11) reads 1. The one exception is the flag clear of R12.
- R5: The unlocked bit clears on the first applied control/status write, or after WIN_CYC clock cycles, whichever comes first.
- R6: Once a control/status write has stored allow-updates (bit 5) as 0, every later unlock key is ignored until reset.
- R7: Reconfiguration-complete (bit 10) becomes 1 on the edge that applies a control/status or limit write. It becomes 0 when an unlock is accepted.
- R8: The refresh key sets the counter to 0 and does not unlock. In 32-bit mode the key is 0xB480A602. In halfword mode it is 0x0000A602 followed directly by 0x0000B480.
- R9: A counter-register write that completes no key leaves the count unchanged.
- R10: With enable (bit 7) set, each step advances the count. The step on which count+1 reaches or passes the limit pulses `rst_req` high for one cycle, sets the flag (bit 14) and restarts the count at 0. An applied configuration write also clears the count.
- R11: With prescaler bit 12 set, a step occurs once every 256 `src_tick` cycles. With it clear, every `src_tick` cycle is a step.
- R12: Writing 1 to bit 14 clears the flag, whether or not the block is unlocked.
- R13: While `core_wait` is high and run-in-wait (bit 1) is 0, the count holds. The same applies to `core_stop` with run-in-stop (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_tick | input | 1 | One-cycle tick of the selected time base |
| core_wait | input | 1 | Processor is in wait mode |
| core_stop | input | 1 | Processor is in stop mode |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with a 16-bit counter and an 8-bit prescaler, so a prescaled timeout arrives 256 ticks after enable. It shrinks the unlock window to 16 cycles. With that window, the bench can observe both the last cycle the window is still open and the cycle it closes by itself, and timing out, re-locking and resetting mid-run all fit in a short run. A limit of 3 gives a timeout that can be counted edge by edge. Resetting mid-run clears the lockout, which brings halfword key mode back into reach.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_COUNT = 4'h4;
  localparam logic [3:0] OFS_LIMIT = 4'h8;

  localparam logic [31:0] KEY_OPEN_W  = 32'hD928_C520;
  localparam logic [31:0] KEY_SERVE_W = 32'hB480_A602;
  localparam logic [31:0] KEY_OPEN_LO  = 32'h0000_C520;
  localparam logic [31:0] KEY_OPEN_HI  = 32'h0000_D928;
  localparam logic [31:0] KEY_SERVE_LO = 32'h0000_A602;
  localparam logic [31:0] KEY_SERVE_HI = 32'h0000_B480;

  localparam int B_STP  = 0;
  localparam int B_WT   = 1;
  localparam int B_UPD  = 5;
  localparam int B_EN   = 7;
  localparam int B_SEL  = 8;
  localparam int B_RCS  = 10;
  localparam int B_ULK  = 11;
  localparam int B_PRE  = 12;
  localparam int B_W32  = 13;
  localparam int B_FLAG = 14;

  typedef enum logic [1:0] {HALF_NONE, HALF_OPEN, HALF_SERVE} half_e;

  typedef struct packed {
    logic       w32;
    logic       pre;
    logic [1:0] sel;
    logic       en;
    logic       upd;
    logic       wt;
    logic       stp;
  } ctl_t;

  function automatic ctl_t ctl_from_word(input logic [31:0] w);
    ctl_t c;
    c.w32 = w[B_W32];
    c.pre = w[B_PRE];
    c.sel = w[B_SEL+1:B_SEL];
    c.en  = w[B_EN];
    c.upd = w[B_UPD];
    c.wt  = w[B_WT];
    c.stp = w[B_STP];
    return c;
  endfunction

  function automatic logic [31:0] ctl_to_word(input ctl_t c, input logic flag,
                                              input logic ulk, input logic rcs);
    logic [31:0] w;
    w = '0;
    w[B_W32] = c.w32;
    w[B_PRE] = c.pre;
    w[B_SEL+1:B_SEL] = c.sel;
    w[B_EN]  = c.en;
    w[B_UPD] = c.upd;
    w[B_WT]  = c.wt;
    w[B_STP] = c.stp;
    w[B_FLAG] = flag;
    w[B_ULK] = ulk;
    w[B_RCS] = rcs;
    return w;
  endfunction
endpackage

// File: rtl/kwd_keydec.sv
`timescale 1ns/1ps
module kwd_keydec
  import kwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_w32,
  input  logic        cnt_wr,
  input  logic        other_wr,
  input  logic [31:0] wdata,
  output logic        open_hit,
  output logic        serve_hit
);
  half_e half_q, half_d;

  always_comb begin
    open_hit  = 1'b0;
    serve_hit = 1'b0;
    half_d    = half_q;
    if (other_wr) begin
      half_d = HALF_NONE;
    end else if (cnt_wr) begin
      half_d = HALF_NONE;
      if (mode_w32) begin
        open_hit  = (wdata == KEY_OPEN_W);
        serve_hit = (wdata == KEY_SERVE_W);
      end else if (half_q == HALF_OPEN && wdata == KEY_OPEN_HI) begin
        open_hit = 1'b1;
      end else if (half_q == HALF_SERVE && wdata == KEY_SERVE_HI) begin
        serve_hit = 1'b1;
      end else if (wdata == KEY_OPEN_LO) begin
        half_d = HALF_OPEN;
      end else if (wdata == KEY_SERVE_LO) begin
        half_d = HALF_SERVE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= HALF_NONE;
    else        half_q <= half_d;
  end
endmodule

// File: rtl/kwd_prescale.sv
`timescale 1ns/1ps
module kwd_prescale #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_tick,
  input  logic pre_en,
  input  logic clr,
  output logic step
);
  logic [PRE_W-1:0] div_q;

  assign step = run_tick && (!pre_en || (&div_q));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)          div_q <= '0;
    else if (run_tick && pre_en) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/kwd_counter.sv
`timescale 1ns/1ps
module kwd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             fire_now,
  output logic             fire_q
);
  localparam logic [CNT_W:0] ONE = 1;
  logic [CNT_W:0] nxt;

  assign nxt      = {1'b0, count} + ONE;
  assign fire_now = step && !clr && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= fire_now;
      if (clr || fire_now) count <= '0;
      else if (step)       count <= nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter int              CNT_W     = 16,
  parameter int              PRE_W     = 8,
  parameter int              WIN_CYC   = 128,
  parameter logic [CNT_W-1:0] TOVAL_RST = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              src_tick,
  input  logic              core_wait,
  input  logic              core_stop,
  output logic              rst_req
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam ctl_t CTL_RST = '{w32: 1'b0, pre: 1'b0, sel: 2'b00, en: 1'b0,
                               upd: 1'b1, wt: 1'b0, stp: 1'b0};

  ctl_t             ctl_q;
  logic             ulk_q, rcs_q, flag_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] toval_q;
  logic [CNT_W-1:0] count;
  logic             open_hit, serve_hit, open_ok;
  logic             cs_wr, to_wr, cnt_wr;
  logic             apply_cs, apply_to, clr, run, step, fire_now;

  assign cs_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign to_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_LIMIT));
  assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));

  assign apply_cs = cs_wr && ulk_q;
  assign apply_to = to_wr && ulk_q;
  assign open_ok  = open_hit && ctl_q.upd;
  assign clr      = serve_hit || apply_cs || apply_to;
  assign run      = ctl_q.en && !(core_wait && !ctl_q.wt) && !(core_stop && !ctl_q.stp);

  kwd_keydec u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_w32 (ctl_q.w32),
    .cnt_wr   (cnt_wr),
    .other_wr (bus_wr && !cnt_wr),
    .wdata    (bus_wdata),
    .open_hit (open_hit),
    .serve_hit(serve_hit)
  );

  kwd_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_tick(src_tick && run),
    .pre_en  (ctl_q.pre),
    .clr     (clr),
    .step    (step)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .clr     (clr),
    .limit   (toval_q),
    .count   (count),
    .fire_now(fire_now),
    .fire_q  (rst_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ulk_q <= 1'b0;
      win_q <= '0;
    end else if (open_ok) begin
      ulk_q <= 1'b1;
      win_q <= '0;
    end else if (ulk_q) begin
      win_q <= win_q + 1'b1;
      if (apply_cs || win_q == WIN_LAST) ulk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RST;
      toval_q <= TOVAL_RST;
      rcs_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (apply_cs) ctl_q <= ctl_from_word(bus_wdata);
      if (apply_to) toval_q <= bus_wdata[CNT_W-1:0];
      if (open_ok)                    rcs_q <= 1'b0;
      else if (apply_cs || apply_to) rcs_q <= 1'b1;
      if (fire_now)                          flag_q <= 1'b1;
      else if (cs_wr && bus_wdata[B_FLAG])   flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_CTRL):  bus_rdata = ctl_to_word(ctl_q, flag_q, ulk_q, rcs_q);
      ADDR_W'(OFS_COUNT): bus_rdata = 32'(count);
      ADDR_W'(OFS_LIMIT): bus_rdata = 32'(toval_q);
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdog_chk.sv
`timescale 1ns/1ps
module keyed_wdog_chk #(
  parameter int CNT_W   = 16,
  parameter int WIN_CYC = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             flag_q,
  input logic             ulk_q,
  input logic             upd_q,
  input logic             open_ok,
  input logic             to_wr,
  input logic             cnt_wr,
  input logic             serve_hit,
  input logic             step,
  input logic [CNT_W-1:0] toval_q,
  input logic [CNT_W-1:0] count
);
  localparam int RUN_W = $clog2(WIN_CYC + 2) + 1;
  logic [RUN_W-1:0] run_c;

  always_ff @(posedge clk) begin
    if (!rst_n || !ulk_q || open_ok) run_c <= '0;
    else                             run_c <= run_c + 1'b1;
  end

  p_fire_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag_q);

  p_window_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ulk_q |-> (run_c < RUN_W'(WIN_CYC)));

  p_locked_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (to_wr && !ulk_q) |=> $stable(toval_q));

  p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> !ulk_q);

  p_refresh_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serve_hit |=> (count == '0));

  p_junk_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !serve_hit && !step) |=> $stable(count));
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_req  (rst_req),
  .flag_q   (flag_q),
  .ulk_q    (ulk_q),
  .upd_q    (ctl_q.upd),
  .open_ok  (open_ok),
  .to_wr    (to_wr),
  .cnt_wr   (cnt_wr),
  .serve_hit(serve_hit),
  .step     (step),
  .toval_q  (toval_q),
  .count    (count)
);

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
  localparam int WIN = 16;
  localparam logic [3:0] A_CS = 4'h0, A_CN = 4'h4, A_TO = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        src_tick = 1'b0;
  logic        core_wait = 1'b0;
  logic        core_stop = 1'b0;
  logic        rst_req;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdog #(.ADDR_W(4), .CNT_W(16), .PRE_W(8), .WIN_CYC(WIN),
               .TOVAL_RST(16'h1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .core_wait(core_wait), .core_stop(core_stop), .rst_req(rst_req)
  );

  typedef struct packed {
    logic        rd;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, A_CS, 32'h0000_0020, 8'd1},   // R1 reset control value
    '{1'b1, A_TO, 32'h0000_1000, 8'd1},   // R1 reset limit
    '{1'b1, A_CN, 32'h0000_0000, 8'd1},   // R1 reset count
    '{1'b0, A_TO, 32'h0000_0005, 8'd4},   // R4 locked limit write
    '{1'b1, A_TO, 32'h0000_1000, 8'd4},
    '{1'b0, A_CN, 32'h0000_C520, 8'd3},   // R3 halfword unlock
    '{1'b0, A_CN, 32'h0000_D928, 8'd3},
    '{1'b1, A_CS, 32'h0000_0820, 8'd3},
    '{1'b0, A_TO, 32'h0000_0007, 8'd7},   // R7 rcs after limit write
    '{1'b1, A_CS, 32'h0000_0C20, 8'd7},
    '{1'b0, A_CS, 32'h0000_2020, 8'd5},   // R5 control write closes window
    '{1'b1, A_CS, 32'h0000_2420, 8'd5},
    '{1'b1, A_TO, 32'h0000_0007, 8'd4},
    '{1'b0, A_CN, 32'h0000_C520, 8'd2},   // R2 halfwords rejected in word mode
    '{1'b0, A_CN, 32'h0000_D928, 8'd2},
    '{1'b1, A_CS, 32'h0000_2420, 8'd2},
    '{1'b0, A_CN, 32'hD928_C520, 8'd2},   // R2 word unlock
    '{1'b1, A_CS, 32'h0000_2820, 8'd7},   // R7 rcs cleared by unlock
    '{1'b0, A_CN, 32'h1234_5678, 8'd9},   // R9 junk counter write
    '{1'b0, A_CS, 32'h0000_20A0, 8'd10},
    '{1'b1, A_CS, 32'h0000_24A0, 8'd10}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, input logic [31:0] exp, input int req);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    src_tick = 1'b1;
    repeat (n) @(negedge clk);
    src_tick = 1'b0;
  endtask

  task automatic first_fire(input int lim, output int at);
    at = 0;
    src_tick = 1'b1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (rst_req && at == 0) at = i;
    end
    src_tick = 1'b0;
  endtask

  initial begin
    int at;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].rd) br(VEC[k].addr, VEC[k].data, int'(VEC[k].req));
      else           bw(VEC[k].addr, VEC[k].data);
    end

    // R10: limit 3, timeout on third step, flag set
    bw(A_CN, 32'hD928_C520);
    bw(A_TO, 32'd3);
    bw(A_CS, 32'h0000_20A0);
    first_fire(4, at);
    chk(10, 32'(at), 32'd3);
    br(A_CS, 32'h0000_64A0, 10);
    // R12: flag clear while locked
    bw(A_CS, 32'h0000_4000);
    br(A_CS, 32'h0000_24A0, 12);
    // R8: word refresh
    bw(A_CN, 32'hB480_A602);
    ticks(2);
    br(A_CN, 32'd2, 10);
    bw(A_CN, 32'hB480_A602);
    br(A_CN, 32'd0, 8);
    br(A_CS, 32'h0000_24A0, 8);
    // R9: junk write keeps count
    ticks(1);
    bw(A_CN, 32'h0000_0055);
    br(A_CN, 32'd1, 9);
    // R13: wait/stop gating
    core_wait = 1'b1; ticks(2); core_wait = 1'b0;
    br(A_CN, 32'd1, 13);
    core_stop = 1'b1; ticks(2); core_stop = 1'b0;
    br(A_CN, 32'd1, 13);
    bw(A_CN, 32'hD928_C520);
    bw(A_CS, 32'h0000_20A3);
    core_wait = 1'b1; ticks(2); core_wait = 1'b0;
    br(A_CN, 32'd2, 13);
    // R11: prescaler
    bw(A_CN, 32'hD928_C520);
    bw(A_TO, 32'd1);
    bw(A_CS, 32'h0000_30A0);
    first_fire(300, at);
    chk(11, 32'(at), 32'd256);
    bw(A_CS, 32'h0000_4000);
    br(A_CS, 32'h0000_34A0, 12);
    // R5: window expiry
    bw(A_CN, 32'hD928_C520);
    repeat (WIN - 2) @(negedge clk);
    br(A_CS, 32'h0000_38A0, 5);
    repeat (3) @(negedge clk);
    br(A_CS, 32'h0000_30A0, 5);
    bw(A_TO, 32'd9);
    br(A_TO, 32'd1, 4);
    // R6: lockout
    bw(A_CN, 32'hD928_C520);
    bw(A_CS, 32'h0000_2080);
    bw(A_CN, 32'hD928_C520);
    br(A_CS, 32'h0000_2480, 6);
    bw(A_TO, 32'd9);
    br(A_TO, 32'd1, 6);
    // R1/R3: reset, then halfword keys
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    br(A_CS, 32'h0000_0020, 1);
    bw(A_CN, 32'h0000_C520);
    bw(A_TO, 32'h0000_0033);
    bw(A_CN, 32'h0000_D928);
    br(A_CS, 32'h0000_0020, 3);
    br(A_TO, 32'h0000_1000, 4);
    bw(A_CN, 32'h0000_C520);
    bw(A_CN, 32'h0000_D928);
    br(A_CS, 32'h0000_0820, 3);
    bw(A_CS, 32'h0000_00A0);
    ticks(2);
    br(A_CN, 32'd2, 10);
    bw(A_CN, 32'h0000_A602);
    bw(A_CN, 32'h0000_B480);
    br(A_CN, 32'd0, 8);
    br(A_CS, 32'h0000_04A0, 8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule